// File: doc/BRIEF.md
# Serial Flash Clock Two-Stage Divider

This block turns a fast input clock into the serial clock for a flash controller. The input clock goes through a coarse pre-divider, by five or by six, and then through a fine even post-divider. The block drives two outputs: the divided clock and a copy at half that rate. Both outputs are registered levels in the input clock domain, with a 50 percent duty cycle.

One five-bit control register sets the divider. It is written and read back over a minimal register bus. Codes the divider cannot use raise an error bit and stop both outputs at low. A newly written code is held back until the divided clock is low, so that a ratio change never produces a shortened pulse.

Top module: `sfclk_div`

## Requirements
- R1: The pre-divide field sits in register bits [4:3]. Code 2 gives a pre-divide ratio of 5 and code 3 gives a ratio of 6.
- R2: The post-divide field sits in register bits [2:0]. An odd code N gives a post-divide ratio of N+1, which is 2, 4, 6 or 8.
- R3: The period of `sf_clk` in input clock cycles equals the pre-divide ratio times the post-divide ratio, for example 48 for codes (3,7). Its high time is exactly half of that period.
- R4: `sf_clk_half` toggles on each rising edge of `sf_clk`, so its high time equals one full `sf_clk` period.
- R5: A pre-divide code of 0 or 1, or an even post-divide code, sets `cfg_err` to 1 from the cycle after the write. Once the value takes effect, both clock outputs stay low.
- R6: `reg_rdata[4:0]` returns the last written register value and `reg_rdata[5]` returns the error bit.
- R7: A written value takes effect only while `sf_clk` is low. A high pulse that is running when the write arrives completes at its old length, and no low phase after the change is shorter than 5 cycles.
- R8: After reset the register reads 5'h1F (codes 3 and 7), `cfg_err` is 0, both outputs are low, and `sf_clk` runs with a period of 48.
- R9: Writing a valid value after an invalid one restarts both outputs at the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | 5 | Write data: pre code in [4:3], post code in [2:0] |
| reg_rdata | output | 6 | Read-back: error bit in [5], register value in [4:0] |
| cfg_err | output | 1 | High while the register holds an unsupported code |
| sf_clk | output | 1 | Divided serial flash clock |
| sf_clk_half | output | 1 | Divided clock further divided by two |

## Verification
Two things can land in the same cycle: a register write and a running high phase of `sf_clk`. The bench runs the clock at ratio 48 and writes ratio 10 three cycles into a high pulse. It then checks that this pulse still lasts 24 cycles, that the low phase after it is at least 5 cycles long, and that the following pulses have the new period. A second overlap is a write of an invalid value while the clock runs: the error bit must rise at once, and the outputs must go quiet only after the current pulse has ended.

// File: rtl/sfclk_pkg.sv
package sfclk_pkg;
  localparam int CFG_W     = 5;
  localparam int PRE_LSB   = 3;
  localparam int PRE_W     = 2;
  localparam int POST_W    = 3;
  localparam int HALF_W    = POST_W - 1;

  typedef struct packed {
    logic              valid;
    logic              pre_six;
    logic [HALF_W-1:0] half_idx;
  } sfclk_cfg_t;

  function automatic sfclk_cfg_t sfclk_decode(input logic [CFG_W-1:0] f);
    sfclk_cfg_t       c;
    logic [PRE_W-1:0] pre;
    logic [POST_W-1:0] post;
    pre        = f[PRE_LSB +: PRE_W];
    post       = f[POST_W-1:0];
    c.valid    = pre[1] & post[0];
    c.pre_six  = pre[0];
    c.half_idx = post[POST_W-1:1];
    return c;
  endfunction
endpackage

// File: rtl/sfclk_regif.sv
module sfclk_regif
  import sfclk_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = 5'h1F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             main_low,
  output logic [CFG_W:0]   rdata,
  output logic             err,
  output sfclk_cfg_t       act,
  output logic             restart
);
  logic [CFG_W-1:0] cfg_q;
  logic             err_q;
  logic             pend_q;
  sfclk_cfg_t       act_q;

  assign restart = pend_q & main_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= RST_CFG;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= sfclk_decode(RST_CFG);
    end else begin
      if (we) begin
        cfg_q  <= wdata;
        err_q  <= ~sfclk_decode(wdata).valid;
        pend_q <= 1'b1;
      end else if (restart) begin
        pend_q <= 1'b0;
      end
      if (restart) act_q <= sfclk_decode(cfg_q);
    end
  end

  assign rdata = {err_q, cfg_q};
  assign err   = err_q;
  assign act   = act_q;

  // R7: the active setting only changes after a cycle where the clock was low
  a_r7_apply_low: assert property (@(posedge clk) disable iff (rst)
    (act_q != $past(act_q)) |-> $past(main_low));

  // R5: an accepted write always leaves a change pending until applied
  a_r5_write_pends: assert property (@(posedge clk) disable iff (rst)
    we |=> pend_q);
endmodule

// File: rtl/sfclk_prediv.sv
module sfclk_prediv #(
  parameter int RATIO_LO = 5,
  parameter int RATIO_HI = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic pre_six,
  output logic tick
);
  localparam int CNT_W = $clog2(RATIO_HI);
  localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(RATIO_LO - 1);
  localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(RATIO_HI - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             tick_q;

  assign lim = pre_six ? LIM_HI : LIM_LO;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == lim) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  // R1: counter never exceeds the selected ratio
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM_HI);

  // R1: ticks are separated by at least one idle cycle (ratio >= 5)
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
endmodule

// File: rtl/sfclk_postdiv.sv
module sfclk_postdiv
  import sfclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              run,
  input  logic              tick,
  input  logic [HALF_W-1:0] half_idx,
  output logic              main_clk,
  output logic              half_clk
);
  logic [HALF_W-1:0] pcnt_q;
  logic              main_q;
  logic              half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      main_q <= 1'b0;
      half_q <= 1'b0;
    end else if (restart) begin
      pcnt_q <= '0;
      main_q <= 1'b0;
    end else if (!run) begin
      pcnt_q <= '0;
      main_q <= 1'b0;
      half_q <= 1'b0;
    end else if (tick) begin
      if (pcnt_q == half_idx) begin
        pcnt_q <= '0;
        main_q <= ~main_q;
        if (!main_q) half_q <= ~half_q;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  assign main_clk = main_q;
  assign half_clk = half_q;

  // R5: an inactive setting forces both outputs low
  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> (!main_q && !half_q));

  // R4: the half-rate output only rises together with the main output
  a_r4_half_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(half_q) |-> $rose(main_q));

  // R3: the main output only moves on a pre-divider tick or when stopping
  a_r3_move_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(main_q) |-> ($past(tick) || !$past(run)));
endmodule

// File: rtl/sfclk_div.sv
module sfclk_div
  import sfclk_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG  = 5'h1F,
  parameter int               RATIO_LO = 5,
  parameter int               RATIO_HI = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [CFG_W-1:0] reg_wdata,
  output logic [CFG_W:0]   reg_rdata,
  output logic             cfg_err,
  output logic             sf_clk,
  output logic             sf_clk_half
);
  sfclk_cfg_t act;
  logic       restart;
  logic       tick;
  logic       main_c;
  logic       half_c;

  sfclk_regif #(.RST_CFG(RST_CFG)) u_regif (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .wdata    (reg_wdata),
    .main_low (~main_c),
    .rdata    (reg_rdata),
    .err      (cfg_err),
    .act      (act),
    .restart  (restart)
  );

  sfclk_prediv #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_prediv (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .run     (act.valid),
    .pre_six (act.pre_six),
    .tick    (tick)
  );

  sfclk_postdiv u_postdiv (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .run      (act.valid),
    .tick     (tick),
    .half_idx (act.half_idx),
    .main_clk (main_c),
    .half_clk (half_c)
  );

  assign sf_clk      = main_c;
  assign sf_clk_half = half_c;
endmodule

// File: tb/test_sfclk_div.sv
`timescale 1ns/1ps
module test_sfclk_div;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [4:0] reg_wdata = '0;
  logic [5:0] reg_rdata;
  logic       cfg_err;
  logic       sf_clk;
  logic       sf_clk_half;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sfclk_div i_sfclk_div (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg_err(cfg_err), .sf_clk(sf_clk),
    .sf_clk_half(sf_clk_half)
  );

  // {err, pad, pre code, post code, expected period}
  localparam logic [15:0] VEC [12] = '{
    {1'b0, 2'b00, 2'd2, 3'd1, 8'd10},
    {1'b0, 2'b00, 2'd3, 3'd3, 8'd24},
    {1'b1, 2'b00, 2'd0, 3'd3, 8'd0},
    {1'b0, 2'b00, 2'd2, 3'd5, 8'd30},
    {1'b1, 2'b00, 2'd1, 3'd5, 8'd0},
    {1'b0, 2'b00, 2'd3, 3'd1, 8'd12},
    {1'b1, 2'b00, 2'd3, 3'd2, 8'd0},
    {1'b0, 2'b00, 2'd2, 3'd7, 8'd40},
    {1'b0, 2'b00, 2'd3, 3'd5, 8'd36},
    {1'b1, 2'b00, 2'd2, 3'd0, 8'd0},
    {1'b0, 2'b00, 2'd2, 3'd3, 8'd20},
    {1'b0, 2'b00, 2'd3, 3'd7, 8'd48}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] v);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic measure(output int hi, output int per);
    int g = 0;
    hi = 0; per = 0;
    while (sf_clk && g < 400) begin @(negedge clk); g++; end
    while (!sf_clk && g < 400) begin @(negedge clk); g++; end
    while (sf_clk && g < 400) begin hi++; per++; @(negedge clk); g++; end
    while (!sf_clk && g < 400) begin per++; @(negedge clk); g++; end
  endtask

  task automatic measure_half(output int hi);
    int g = 0;
    hi = 0;
    while (sf_clk_half && g < 800) begin @(negedge clk); g++; end
    while (!sf_clk_half && g < 800) begin @(negedge clk); g++; end
    while (sf_clk_half && g < 800) begin hi++; @(negedge clk); g++; end
  endtask

  initial begin
    int hi, per, lo, highs;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(reg_rdata == 6'h1F, "R8 rdata after reset", reg_rdata, 6'h1F);
    chk(!cfg_err, "R8 err after reset", cfg_err, 0);
    chk(!sf_clk && !sf_clk_half, "R8 outputs low after reset", sf_clk, 0);
    measure(hi, per);
    chk(per == 48, "R8 reset period", per, 48);
    chk(hi == 24, "R8 reset high time", hi, 24);

    foreach (VEC[i]) begin
      logic [4:0] code;
      int exp_per;
      bit exp_err;
      code    = VEC[i][12:8];
      exp_per = int'(VEC[i][7:0]);
      exp_err = VEC[i][15];
      wr(code);
      chk(reg_rdata == {exp_err, code}, "R6 readback", reg_rdata, {exp_err, code});
      chk(cfg_err == exp_err, "R5 error flag", cfg_err, exp_err);
      repeat (60) @(negedge clk);
      if (exp_err) begin
        highs = 0;
        for (int k = 0; k < 100; k++) begin
          if (sf_clk || sf_clk_half) highs++;
          @(negedge clk);
        end
        chk(highs == 0, "R5 outputs held low", highs, 0);
      end else begin
        measure(hi, per);
        chk(per == exp_per, "R1/R2/R3 period (R9 after invalid)", per, exp_per);
        chk(hi == exp_per / 2, "R3 duty", hi, exp_per / 2);
        measure_half(hi);
        chk(hi == exp_per, "R4 half-rate high time", hi, exp_per);
      end
    end

    // R7: write lands while sf_clk is high (ratio 48 -> 10)
    wr(5'h1F);
    repeat (120) @(negedge clk);
    while (sf_clk) @(negedge clk);
    while (!sf_clk) @(negedge clk);
    hi = 0;
    while (sf_clk && hi < 200) begin
      hi++;
      if (hi == 3) begin reg_we = 1'b1; reg_wdata = 5'h11; end
      if (hi == 4) reg_we = 1'b0;
      @(negedge clk);
    end
    chk(hi == 24, "R7 running pulse keeps old length", hi, 24);
    lo = 0;
    while (!sf_clk && lo < 200) begin lo++; @(negedge clk); end
    chk(lo >= 5, "R7 no short low phase", lo, 5);
    measure(hi, per);
    chk(per == 10, "R7 new period after switch", per, 10);

    // R5/R7: invalid write during a high phase stops outputs after the pulse
    wr(5'h1F);
    repeat (120) @(negedge clk);
    while (!sf_clk) @(negedge clk);
    wr(5'h0B);
    chk(cfg_err == 1'b1, "R5 error rises at once", cfg_err, 1);
    chk(sf_clk == 1'b1, "R7 pulse not cut by invalid write", sf_clk, 1);
    repeat (60) @(negedge clk);
    chk(!sf_clk && !sf_clk_half, "R5 stopped after pulse", sf_clk, 0);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule